// File: doc/BRIEF.md
# Base-85 Text to Word Decoder

This block turns a stream of 8-bit text characters, one per cycle, into 32-bit data words using base-85 text encoding. Each record is one line of text. It begins with one or more spaces of indentation, which are dropped, and it ends with a line-feed character. In between, each group of five characters from the printable alphabet forms one word. A lone `z` at a group boundary stands for a whole zero word.

At the line end, any group still in progress is sent out as it stands, with no padding. After that the block sends zero words until the record holds the number of words the caller declared for it, so the consumer always receives a buffer of full length. Each output word carries its index within the record. A one-cycle done pulse closes the record once the last word has left. A sticky error flag reports malformed text: a missing indent, characters outside the alphabet, and groups whose value does not fit in 32 bits. Malformed characters are still decoded as ordinary digits.

Both sides use valid/ready handshakes. A full output register stalls the character input.

Top module: `a85_word_decoder`

## Requirements
- R1: Space characters (0x20) at the start of a record are discarded. If the first non-space character of a record has no space before it, `err` is set, and that character is still decoded normally.
- R2: The character `z` (0x7A), accepted while no group is in progress, emits one word of value 0x00000000 on its own.
- R3: Five consecutive digit characters emit one word. The word's value is the sum over the group of (code − 0x21) × 85^k, with the first character taking the highest power, computed modulo 2^32.
- R4: A line feed (0x0A) that arrives while a group is in progress emits the value of the digits collected so far, with no padding digits added.
- R5: After the line feed, zero words are emitted until the record has produced `rec_len` words. `rec_len` is sampled when the record's first non-space character is accepted. `rec_done` then pulses high for one cycle, and only when no output word is pending.
- R6: `out_index` is 0 for the first word of every record and rises by one for each later word of that record.
- R7: While `out_valid` is high and `out_ready` is low, the output word and index hold steady and `in_ready` is low. `in_ready` is also low while the zero fill is running.
- R8: A digit step whose exact value (accumulator × 85 + code − 0x21) exceeds 0xFFFFFFFF sets `err`. Once set, `err` stays high until reset.
- R9: A digit character outside 0x21..0x75 sets `err` and is decoded with digit value (code − 0x21) modulo 2^32. This includes a `z` inside a group and a space after the indent.
- R10: After reset, `out_valid`, `rec_done` and `err` are low and `in_ready` is high.
- R11: A line feed with no group in progress emits no word of its own, so an empty record with `rec_len` 0 produces only `rec_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character present |
| in_char | input | 8 | Text character |
| in_ready | output | 1 | Character accepted this cycle when high with `in_valid` |
| rec_len | input | IDX_W | Declared word count of the record; sampled at its first non-space character |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Decoded word |
| out_index | output | IDX_W | Position of the word within its record |
| rec_done | output | 1 | One-cycle pulse when a record is complete |
| err | output | 1 | Sticky malformed-input flag |

## Verification
The assertions assume the consumer follows the usual valid/ready rule. They also assume `rec_len` does not change while the first non-space character of a record is being offered. The bench drives `rec_len` once per record, before that record's first character, and holds it until the done pulse.

Stimulus mixes legal groups with deliberate malformed and overflowing ones. Because `err` is sticky, the bench's model carries the expected flag across records and resets only between directed scenarios. Throughout the run, `out_ready` is toggled at random, except in one phase where it is held low to show the stall.

// File: rtl/a85_pkg.sv
package a85_pkg;
   localparam logic [7:0] ALPHA_LO = 8'h21;
   localparam logic [7:0] ALPHA_HI = 8'h75;
   localparam logic [7:0] CH_NL    = 8'h0A;
   localparam logic [7:0] CH_SP    = 8'h20;
   localparam logic [7:0] CH_ZERO  = 8'h7A;
   localparam int         RADIX    = 85;

   typedef enum logic [1:0] {ST_LEAD, ST_BODY, ST_FILL} dec_state_e;

   typedef struct packed {
      logic sp;
      logic nl;
      logic zc;
      logic bad;
   } char_cls_t;
endpackage

// File: rtl/a85_char_class.sv
module a85_char_class
   import a85_pkg::*;
(
   input  logic [7:0] ch,
   output char_cls_t  cls
);
   always_comb begin
      cls.sp  = (ch == CH_SP);
      cls.nl  = (ch == CH_NL);
      cls.zc  = (ch == CH_ZERO);
      cls.bad = !((ch >= ALPHA_LO) && (ch <= ALPHA_HI)) && (ch != CH_NL);
   end
endmodule

// File: rtl/a85_group_acc.sv
module a85_group_acc
   import a85_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int GRP    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              clear,
   input  logic [7:0]        ch,
   output logic [WORD_W-1:0] acc_q,
   output logic [WORD_W-1:0] step,
   output logic              step_ovf,
   output logic              last,
   output logic              partial
);
   localparam int CNT_W  = $clog2(GRP + 1);
   localparam int WIDE_W = WORD_W + 8;

   if (GRP < 2 || GRP > 8) begin : g_bad_grp
      $error("a85_group_acc: GRP out of range");
   end
   if (WORD_W < 8) begin : g_bad_word
      $error("a85_group_acc: WORD_W too small");
   end

   logic [CNT_W-1:0]  n_q;
   logic [WIDE_W-1:0] wide, sub;

   always_comb begin
      wide     = WIDE_W'(acc_q) * WIDE_W'(RADIX) + WIDE_W'(ch);
      sub      = wide - WIDE_W'(ALPHA_LO);
      step     = sub[WORD_W-1:0];
      step_ovf = (wide >= WIDE_W'(ALPHA_LO)) && (sub[WIDE_W-1:WORD_W] != '0);
      last     = (n_q == CNT_W'(GRP - 1));
      partial  = (n_q != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc_q <= '0;
         n_q   <= '0;
      end else if (push) begin
         if (last) begin
            acc_q <= '0;
            n_q   <= '0;
         end else begin
            acc_q <= step;
            n_q   <= n_q + CNT_W'(1);
         end
      end
   end

   AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && last && !clear) |=> !partial); // R3
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!partial && acc_q == '0)); // R4
endmodule

// File: rtl/a85_word_decoder.sv
module a85_word_decoder
   import a85_pkg::*;
#(
   parameter int IDX_W     = 12,
   parameter bit ZERO_FILL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_char,
   output logic             in_ready,
   input  logic [IDX_W-1:0] rec_len,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [31:0]      out_word,
   output logic [IDX_W-1:0] out_index,
   output logic             rec_done,
   output logic             err
);
   localparam int WORD_W = 32;

   if (IDX_W < 1 || IDX_W > 24) begin : g_bad_idx
      $error("a85_word_decoder: IDX_W out of range");
   end

   char_cls_t         cls;
   dec_state_e        st_q, st_d;
   logic [WORD_W-1:0] acc_q, step;
   logic              step_ovf, last, partial;
   logic [IDX_W-1:0]  cnt_q;
   logic              lead_seen_q, ov_q, done_q, err_q;
   logic              acc_char, out_free, lead_sp, body, nl_ev, z_ev, dig_ev;
   logic              load, fill_ev, end_ev, err_set, fill_need;
   logic [WORD_W-1:0] load_word;

   a85_char_class u_cls (.ch(in_char), .cls(cls));

   a85_group_acc #(.WORD_W(WORD_W), .GRP(5)) u_acc (
      .clk(clk), .rst_n(rst_n), .push(dig_ev), .clear(nl_ev), .ch(in_char),
      .acc_q(acc_q), .step(step), .step_ovf(step_ovf), .last(last), .partial(partial));

   if (ZERO_FILL) begin : g_fill
      logic [IDX_W-1:0] len_q;
      always_ff @(posedge clk) begin
         if (!rst_n) len_q <= '0;
         else if (body && st_q == ST_LEAD) len_q <= rec_len;
      end
      assign fill_need = (cnt_q < len_q);
   end else begin : g_nofill
      assign fill_need = 1'b0;
   end

   always_comb begin
      out_free = !ov_q || out_ready;
      in_ready = (st_q != ST_FILL) && out_free;
      acc_char = in_valid && in_ready;
      lead_sp  = (st_q == ST_LEAD) && cls.sp;
      body     = acc_char && !lead_sp;
      nl_ev    = body && cls.nl;
      z_ev     = body && cls.zc && !partial;
      dig_ev   = body && !cls.nl && !z_ev;
      fill_ev  = (st_q == ST_FILL) && fill_need && out_free;
      end_ev   = (st_q == ST_FILL) && !fill_need && !ov_q;
      load     = (nl_ev && partial) || z_ev || (dig_ev && last) || fill_ev;
      if (nl_ev)                load_word = acc_q;
      else if (z_ev || fill_ev) load_word = '0;
      else                      load_word = step;
      err_set  = (dig_ev && (cls.bad || step_ovf)) ||
                 (body && st_q == ST_LEAD && !lead_seen_q);
      st_d = st_q;
      case (st_q)
         ST_LEAD: if (body) st_d = cls.nl ? ST_FILL : ST_BODY;
         ST_BODY: if (nl_ev) st_d = ST_FILL;
         ST_FILL: if (end_ev) st_d = ST_LEAD;
         default: st_d = ST_LEAD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_LEAD;
         cnt_q       <= '0;
         lead_seen_q <= 1'b0;
         ov_q        <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         out_word    <= '0;
         out_index   <= '0;
      end else begin
         st_q   <= st_d;
         done_q <= end_ev;
         if (err_set) err_q <= 1'b1;
         if (end_ev) lead_seen_q <= 1'b0;
         else if (acc_char && lead_sp) lead_seen_q <= 1'b1;
         if (end_ev) cnt_q <= '0;
         else if (load) cnt_q <= cnt_q + IDX_W'(1);
         if (load) begin
            ov_q      <= 1'b1;
            out_word  <= load_word;
            out_index <= cnt_q;
         end else if (out_ready) begin
            ov_q <= 1'b0;
         end
      end
   end

   assign out_valid = ov_q;
   assign rec_done  = done_q;
   assign err       = err_q;

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_index))); // R7
   AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R7
   AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done |-> !out_valid); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done |=> !rec_done); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R8
   AST_IDX_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid || out_index == $past(out_index) + IDX_W'(1))); // R6
endmodule

// File: tb/sim_a85_word_decoder.sv
module sim_a85_word_decoder;
   localparam int IDX_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_char = 8'h0;
   logic             in_ready;
   logic [IDX_W-1:0] rec_len = '0;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic [31:0]      out_word;
   logic [IDX_W-1:0] out_index;
   logic             rec_done;
   logic             err;

   int          n_chk = 0, n_fail = 0, done_cnt = 0, exp_idx = 0;
   bit          stall_hold = 1'b0, model_err = 1'b0;
   logic [31:0] exp_w[$];
   string       cur_tag = "R10";

   always #2 clk = ~clk;

   a85_word_decoder #(.IDX_W(IDX_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
      .rec_len(rec_len), .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .out_index(out_index), .rec_done(rec_done), .err(err));

   task automatic check(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) out_ready = 1'b0;
      else begin
         out_ready = stall_hold ? 1'b0 : ($urandom % 4 != 0);
         if (rec_done) done_cnt++;
         if (out_valid && out_ready) begin
            if (exp_w.size() == 0) check(1'b0, {cur_tag, " R5 extra word"}, out_word, 0);
            else begin
               check(out_word == exp_w[0], {cur_tag, " word"}, out_word, exp_w[0]);
               check(out_index == IDX_W'(exp_idx), "R6 index", out_index, exp_idx);
               void'(exp_w.pop_front());
               exp_idx++;
            end
         end
      end
   end

   task automatic model_record(string s, int len);
      bit lead = 1'b1, seen = 1'b0;
      int n = 0, cnt = 0, c;
      longint acc = 0, w;
      for (int i = 0; i < s.len(); i++) begin
         c = s[i];
         if (lead && c == 32) begin seen = 1'b1; continue; end
         if (lead) begin lead = 1'b0; if (!seen) model_err = 1'b1; end
         if (c == 10) begin
            if (n > 0) begin exp_w.push_back(acc[31:0]); cnt++; end
            break;
         end
         if (c == 122 && n == 0) begin exp_w.push_back(32'h0); cnt++; continue; end
         if (c < 33 || c > 117) model_err = 1'b1;
         w = acc * 85 + c - 33;
         if (w > 64'hFFFF_FFFF) model_err = 1'b1;
         acc = w & 64'hFFFF_FFFF;
         n++;
         if (n == 5) begin exp_w.push_back(acc[31:0]); cnt++; acc = 0; n = 0; end
      end
      while (cnt < len) begin exp_w.push_back(32'h0); cnt++; end
   endtask

   task automatic send_rec(string s, int len, string tag);
      int d0;
      cur_tag = tag;
      exp_idx = 0;
      model_record(s, len);
      d0 = done_cnt;
      @(negedge clk);
      rec_len = IDX_W'(len);
      for (int i = 0; i < s.len(); i++) begin
         repeat ($urandom % 3) begin @(negedge clk); in_valid = 1'b0; end
         @(negedge clk);
         in_valid = 1'b1;
         in_char  = s[i];
         #1;
         while (!in_ready) begin @(negedge clk); #1; end
      end
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 3000 && done_cnt == d0; k++) @(negedge clk);
      check(done_cnt == d0 + 1, {tag, " R5 done"}, done_cnt - d0, 1);
      check(exp_w.size() == 0, {tag, " R5 all words"}, exp_w.size(), 0);
      check(err == model_err, {tag, " err"}, err, model_err);
      exp_w.delete();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b0;
      model_err = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(4 * 150000);
      check(1'b0, "R5 watchdog", 0, 1);
      summary();
      $finish;
   end

   initial begin
      string s;
      int c, ng;
      logic [31:0] w0;
      void'($urandom(32'h5EED_A85));
      do_reset();
      @(negedge clk); #1;
      check(!out_valid, "R10 out_valid", out_valid, 0);
      check(!rec_done, "R10 rec_done", rec_done, 0);
      check(!err, "R10 err", err, 0);
      check(in_ready, "R10 in_ready", in_ready, 1);

      send_rec("   s8W-!\n", 1, "R1 R3");
      send_rec(" z87cURz\n", 3, "R2");
      send_rec(" 9j\n", 0, "R4");
      send_rec(" 87cUR9j\n", 5, "R4 R5");
      send_rec(" \n", 0, "R11");
      send_rec(" z\n", 4, "R5 R11");
      send_rec(" <+U,m\n", 1, "R3");
      check(!err, "R9 no false error", err, 0);
      send_rec("z\n", 1, "R1");
      do_reset();
      send_rec(" uuuuu\n", 1, "R8");
      send_rec(" !!!!!\n", 1, "R8 sticky");
      do_reset();
      send_rec(" {!!!!\n", 1, "R9");
      do_reset();
      send_rec(" !z!!!\n", 1, "R9 z in group");
      do_reset();
      send_rec("  ! !!!\n", 1, "R9 inner space");
      do_reset();

      stall_hold = 1'b1;
      fork
         send_rec(" s8W-!zz\n", 3, "R7");
         begin
            @(negedge clk); #1;
            while (!out_valid) begin @(negedge clk); #1; end
            w0 = out_word;
            repeat (4) begin
               @(negedge clk); #1;
               check(out_valid && out_word == w0, "R7 hold word", out_word, w0);
               check(!in_ready, "R7 in_ready low", in_ready, 0);
            end
            stall_hold = 1'b0;
         end
      join

      do_reset();
      for (int r = 0; r < 40; r++) begin
         s = " ";
         ng = $urandom_range(0, 6);
         for (int g = 0; g < ng; g++) begin
            if ($urandom % 6 == 0) s = {s, "z"};
            else for (int k = 0; k < 5; k++) begin
               c = 33 + $urandom_range(0, 84);
               s = $sformatf("%s%c", s, c);
            end
         end
         for (int k = $urandom_range(0, 4); k > 0; k--) begin
            c = 33 + $urandom_range(0, 84);
            s = $sformatf("%s%c", s, c);
         end
         s = {s, "\n"};
         send_rec(s, $urandom_range(0, ng + 3), "R3 R6 random");
      end

      summary();
      $finish;
   end
endmodule